// File: doc/BRIEF.md
# Prescaled Countdown Timer

A per-processor countdown timer on a small word-addressed register bus. Software places a period in the load register and picks a divide ratio and a repeat mode in the control word. Once enabled, the timer counts down to zero. A divider sits in front of the counter, so the count drops by one every (divide + 1) clock cycles.

Reaching zero sets a sticky status flag. If the repeat mode is on, the counter refills from the load register and keeps running. If it is off, the counter halts at zero. Software clears the flag by writing a one to it. The flag is turned into a single-cycle interrupt pulse for an external interrupt controller, and that pulse fires only when the flag goes from clear to set.

The bus is plain register access with no flow control. A write takes effect at the clock edge where it is presented. The read data is a combinational function of the address. Every access completes in one cycle and there is no back-pressure.

Top module: `cpu_countdown_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_pulse` is low. The word index is `bus_addr[3:2]`: 0 is load, 1 is count, 2 is control and 3 is status. Control keeps only bit 0 (enable), bit 1 (repeat) and bits [15:8] (divide), and reads 0 in every other bit. Status sits in bit 0.
- R2: While enabled with a nonzero count, the count drops by one every (divide + 1) cycles. The first drop comes (divide + 1) edges after the edge that enabled, loaded or rewrote the counter.
- R3: A read of the count word returns 0 when enable is clear or the count is zero. Otherwise it returns the live count.
- R4: A write to the count word replaces the count and restarts the divider, so a running countdown begins again from the written value.
- R5: A write to the load word stores the period and also replaces the count at once.
- R6: When enable goes from 0 to 1 with the count at zero and repeat requested in the same write, the count is refilled from the load register. Without repeat, a zero count stays at zero.
- R7: When the count steps from 1 to 0, the status flag is set. With repeat on, the count refills from the load register. With repeat off, it stays at 0.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If an expiry and a clear land on the same edge, the expiry wins.
- R9: `irq_pulse` is high for exactly the one cycle after the status flag rises. It stays low while the flag remains set, even if further expiries occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Byte address; bits [3:2] pick the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational |
| irq_pulse | output | 1 | Single-cycle interrupt request |

## Verification
The bench times expiry to the exact edge for several divide and period pairs, with and without repeat. An off-by-one divider or a counter that expires on reaching 1 instead of 0 would set the flag one period early or late. It rewrites the count in the middle of a countdown, so a design that ignored the write or kept the old divider phase would expire at the wrong edge. It also enables from zero with and without repeat, so a design that skipped the refill, or refilled regardless of the mode, would read back the wrong count. Finally, it lets a repeating timer expire a second time while the flag is still set, so a design that pulsed on every expiry instead of on flag rise would raise a second interrupt.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  // Word index, taken from bus_addr[3:2]
  localparam logic [1:0] REG_LOAD  = 2'd0;
  localparam logic [1:0] REG_COUNT = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  // Control word field positions
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RPT_BIT = 1;
  localparam int CTRL_DIV_LSB = 8;

  typedef struct packed {
    logic [7:0] div;
    logic       rpt;
    logic       en;
  } ctm_ctrl_t;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] limit,
  output logic          tick
);
  logic [PW-1:0] phase_q;

  assign tick = run && !restart && (phase_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || !run || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [CW-1:0] set_val,
  input  logic          tick,
  input  logic          rpt,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  assign expire = tick && !set_en && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (set_en) begin
      count <= set_val;
    end else if (expire) begin
      count <= rpt ? period : '0;
    end else if (tick) begin
      count <= count - ONE;
    end
  end
endmodule

// File: rtl/ctm_status.sv
module ctm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic pulse
);
  logic flag_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      flag_prev_q <= 1'b0;
    end else begin
      flag_prev_q <= flag;
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign pulse = flag && !flag_prev_q;
endmodule

// File: rtl/cpu_countdown_timer.sv
module cpu_countdown_timer #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_pulse
);
  import ctm_pkg::*;

  localparam int DIV_MSB = CTRL_DIV_LSB + PW - 1;

  logic [1:0]    word;
  logic          wr_hit, wr_load, wr_count, wr_ctrl, wr_stat;
  logic [DW-1:0] load_q;
  logic [DW-1:0] count_q;
  logic          en_q, rpt_q;
  logic [PW-1:0] div_q;
  logic          rise_en, zero_refill, set_en, restart, run, tick, expire;
  logic [DW-1:0] set_val;
  logic          status_q;

  assign word     = bus_addr[3:2];
  assign wr_hit   = bus_sel && bus_wr;
  assign wr_load  = wr_hit && (word == REG_LOAD);
  assign wr_count = wr_hit && (word == REG_COUNT);
  assign wr_ctrl  = wr_hit && (word == REG_CTRL);
  assign wr_stat  = wr_hit && (word == REG_STAT);

  assign rise_en     = wr_ctrl && bus_wdata[CTRL_EN_BIT] && !en_q;
  assign zero_refill = rise_en && bus_wdata[CTRL_RPT_BIT] && (count_q == '0);
  assign set_en      = wr_load || wr_count || zero_refill;
  assign set_val     = (wr_load || wr_count) ? bus_wdata : load_q;
  assign restart     = set_en || rise_en;
  assign run         = en_q && (count_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      en_q   <= 1'b0;
      rpt_q  <= 1'b0;
      div_q  <= '0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      if (wr_ctrl) begin
        en_q  <= bus_wdata[CTRL_EN_BIT];
        rpt_q <= bus_wdata[CTRL_RPT_BIT];
        div_q <= bus_wdata[DIV_MSB:CTRL_DIV_LSB];
      end
    end
  end

  ctm_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .limit(div_q), .tick(tick)
  );

  ctm_counter #(.CW(DW)) u_count (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_val(set_val),
    .tick(tick), .rpt(rpt_q), .period(load_q),
    .count(count_q), .expire(expire)
  );

  ctm_status u_stat (
    .clk(clk), .rst_n(rst_n), .set(expire),
    .clr(wr_stat && bus_wdata[0]),
    .flag(status_q), .pulse(irq_pulse)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (word)
      REG_LOAD:  bus_rdata = load_q;
      REG_COUNT: bus_rdata = run ? count_q : '0;
      REG_CTRL: begin
        bus_rdata[CTRL_EN_BIT]          = en_q;
        bus_rdata[CTRL_RPT_BIT]         = rpt_q;
        bus_rdata[DIV_MSB:CTRL_DIV_LSB] = div_q;
      end
      REG_STAT:  bus_rdata[0] = status_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [1:0]    word,
  input logic          wbit0,
  input logic          en,
  input logic          rpt,
  input logic [DW-1:0] count,
  input logic          status,
  input logic          irq
);
  logic any_wr;
  assign any_wr = bus_sel && bus_wr;

  assert_irq_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && !$past(status)));

  assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !(any_wr && word == 2'd3 && wbit0)) |=> status);

  assert_halt_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rpt && count == '0 && !any_wr) |=> (count == '0));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count > DW'(1) && !any_wr) |=>
      (count == $past(count) || count == $past(count) - DW'(1)));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !any_wr) |=> $stable(count));
endmodule

bind cpu_countdown_timer ctm_checker #(.DW(DW)) u_ctm_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .word(word), .wbit0(bus_wdata[0]), .en(en_q), .rpt(rpt_q),
  .count(count_q), .status(status_q), .irq(irq_pulse)
);

// File: tb/test_cpu_countdown_timer.sv
module test_cpu_countdown_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;

  // {divide[7:0], period[15:0], repeat}
  localparam int NVEC = 4;
  localparam logic [24:0] VEC [NVEC] = '{
    {8'd0, 16'd5, 1'b0},
    {8'd3, 16'd4, 1'b1},
    {8'd1, 16'd1, 1'b0},
    {8'd7, 16'd3, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;
  int          n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_countdown_timer i_cpu_countdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LOAD, v); check("R1 load reset", v, 0);
    rd(A_CNT, v);  check("R1 count reset", v, 0);
    rd(A_CTRL, v); check("R1 ctrl reset", v, 0);
    rd(A_STAT, v); check("R1 status reset", v, 0);
    check("R1 irq reset", {31'b0, irq_pulse}, 0);

    // Table walk: R2, R7, R9
    for (int i = 0; i < NVEC; i++) begin
      int p, n, per;
      logic ar, seen;
      p = int'(VEC[i][24:17]); n = int'(VEC[i][16:1]); ar = VEC[i][0];
      per = (p + 1) * n;
      wr(A_CTRL, 0);
      wr(A_STAT, 1);
      wr(A_LOAD, 32'(n));
      wr(A_CTRL, {16'h0, 8'(p), 6'b0, ar, 1'b1});
      edges(per - 1);
      rd(A_STAT, v); check("R2 no early expiry", v, 0);
      check("R9 no early irq", {31'b0, irq_pulse}, 0);
      edges(1);
      rd(A_STAT, v); check("R7 expiry sets status", v, 1);
      check("R9 irq on rise", {31'b0, irq_pulse}, 1);
      rd(A_CNT, v);  check("R7 count after expiry", v, ar ? 32'(n) : 0);
      edges(1);
      check("R9 irq one cycle", {31'b0, irq_pulse}, 0);
      if (ar) begin
        seen = 1'b0;
        for (int k = 0; k < per; k++) begin
          @(negedge clk);
          seen |= irq_pulse;
        end
        check("R9 no pulse while set", {31'b0, seen}, 0);
        rd(A_STAT, v); check("R8 status sticky", v, 1);
      end
    end

    // R5 / R3 / R1 field masking
    wr(A_CTRL, 0);
    wr(A_LOAD, 9);
    rd(A_LOAD, v); check("R5 load stored", v, 9);
    rd(A_CNT, v);  check("R3 reads 0 when disabled", v, 0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R1 ctrl fields only", v, 32'h0000_FF03);
    rd(A_CNT, v);  check("R3 live count", v, 9);
    wr(A_LOAD, 32'h20);
    rd(A_CNT, v);  check("R5 load replaces count", v, 32'h20);

    // R4 restart by count write
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'h0000_0201);
    edges(4);
    wr(A_CNT, 3);
    edges(8);
    rd(A_STAT, v); check("R4 no early expiry", v, 0);
    edges(1);
    rd(A_STAT, v); check("R4 expiry from written count", v, 1);
    edges(5);
    rd(A_CNT, v);  check("R7 halted at zero", v, 0);

    // R8 write-one-to-clear
    wr(A_STAT, 0);
    rd(A_STAT, v); check("R8 write 0 keeps", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R8 write 1 clears", v, 0);

    // R6 enable from zero
    wr(A_CTRL, 0);
    wr(A_CTRL, 32'h0000_0003);
    rd(A_CNT, v);  check("R6 refill on enable", v, 100);
    wr(A_CTRL, 0);
    wr(A_CNT, 0);
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CNT, v);  check("R6 no refill without repeat", v, 0);
    edges(3);
    rd(A_STAT, v); check("R6 zero count stays idle", v, 0);
    check("R9 no irq when idle", {31'b0, irq_pulse}, 0);

    finish_run();
  end
endmodule